// File: doc/BRIEF.md
# Quad Digital Potentiometer Two-Wire Write Controller

This block is the serial front end of a four-channel digital potentiometer. It watches an open-drain two-wire bus (a clock line and a data line), finds START and STOP conditions, and shifts in a three-byte write. The first byte is the device select. The second byte picks a target register. The third byte carries the value. The block acknowledges each byte it accepts by pulling the data line low during the ninth clock. Reads and multi-byte bursts are not handled.

Each potentiometer has an 8-bit wiper register that sets the tap position. Each potentiometer also has a bank of data registers that stand in for non-volatile storage. A small steering register and a write-protect pin decide what a potentiometer write reaches. If non-volatile mode is off, or writes are protected, only the wiper changes. If non-volatile mode is on and the pin allows it, the wiper changes at STOP and a data register is queued. A fixed-length busy window then opens. During that window the block is deaf to the bus. The data register is written when the window closes.

All bus inputs are sampled by the block clock through two flip-flops. The bus must therefore run many times slower than the clock.

Top module: `qpot_ctrl`

## Requirements
- R1: After reset all wipers, data registers and the steering register read 0, busy_o is 0 and sda_oe_o is 0.
- R2: The device-select byte is acknowledged only when bits 7:4 equal 0101, bits 3:1 equal hw_addr_i and bit 0 (direction) is 0. Any other value gets no acknowledge. The block then stays silent, and changes no register, until the next START.
- R3: For an accepted transfer, sda_oe_o is high during the ninth clock of each of the three bytes. It is low while SCL is high during every data bit.
- R4: Register address 0x07 writes the steering register. Bit 0 is the non-volatile enable and bits 2:1 are the data-register index. Bits 7:3 of status_o always read 0.
- R5: Register addresses 0 to 3 select a potentiometer. If the steering register's enable bit is 0, or wp_i is 0, the data byte lands in that wiper at STOP. No busy window follows, and no data register changes.
- R6: If the enable bit is 1 and wp_i is 1, a potentiometer write updates the wiper at STOP. busy_o is then high for exactly BUSY_CYCLES clock cycles. When busy_o falls, data register [pot][index] holds the byte. The data registers are packed as dreg_o[(pot*NDR+index)*8 +: 8].
- R7: While busy_o is high, the block never acknowledges. A transfer begun inside the busy window changes no register.
- R8: A register changes only on a STOP that follows three acknowledged bytes. A transfer cut short by STOP, or by a repeated START, changes nothing.
- R9: Register addresses 4 to 6 and 8 to 255 are acknowledged but change no register.
- R10: When the busy window closes, the block again acknowledges its own device-select byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 = pull the data line low (acknowledge) |
| hw_addr_i | input | 3 | Strapped device-select bits |
| wp_i | input | 1 | 1 = non-volatile writes allowed |
| wiper_o | output | NPOT*8 | Wiper registers, pot p at [p*8 +: 8] |
| dreg_o | output | NPOT*NDR*8 | Data registers |
| status_o | output | 8 | Steering register |
| busy_o | output | 1 | Non-volatile write window in progress |

## Verification
A fault in the bit counter or in the shift register shows up at the first acknowledge slot. A device-select value is then acknowledged or refused wrongly, so the sweep over all 256 device-select values catches it within one byte. A wrong decode or steering state shows up at the wiper or data-register outputs a few clocks after STOP. A wrong busy counter shows up as a window whose length differs from BUSY_CYCLES. It can also show up as an acknowledge given inside the window, which is visible within one byte time.

// File: rtl/qpot_pkg.sv
package qpot_pkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b0101;
  localparam logic [7:0] STATUS_ADDR = 8'h07;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADR, ST_ADR_ACK,
    ST_DAT, ST_DAT_ACK, ST_WAIT_STOP, ST_IGNORE
  } eng_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_req_t;

  // Device-select byte accepted: type nibble, strap bits, write direction.
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] hw);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == hw) && !b[0];
  endfunction

  // Register address names one of npot potentiometers.
  function automatic logic pot_in_range(input logic [7:0] a, input int npot);
    return int'({24'b0, a}) < npot;
  endfunction

endpackage

// File: rtl/qpot_bus_edge.sv
module qpot_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] stg1, stg2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= 2'b11;
      stg2 <= 2'b11;
      prev <= 2'b11;
    end else begin
      stg1 <= {scl_i, sda_i};
      stg2 <= stg1;
      prev <= stg2;
    end
  end

  always_comb begin
    scl_s     = stg2[1];
    sda_s     = stg2[0];
    scl_rise  = stg2[1] & ~prev[1];
    scl_fall  = ~stg2[1] & prev[1];
    start_det = stg2[1] & prev[1] & prev[0] & ~stg2[0];
    stop_det  = stg2[1] & prev[1] & ~prev[0] & stg2[0];
  end
endmodule

// File: rtl/qpot_byte_engine.sv
module qpot_byte_engine
  import qpot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       busy_i,
  input  logic [2:0] hw_addr_i,
  output logic       sda_oe_o,
  output logic       dev_hit_o,
  output logic       commit_o,
  output wr_req_t    req_o
);
  eng_state_e state;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       shifting;
  logic       byte_full;

  always_comb begin
    shifting  = (state == ST_DEV) || (state == ST_ADR) || (state == ST_DAT);
    byte_full = (bitcnt == 4'd8);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      sda_oe_o  <= 1'b0;
      dev_hit_o <= 1'b0;
      commit_o  <= 1'b0;
      req_o     <= '0;
    end else begin
      commit_o  <= 1'b0;
      dev_hit_o <= 1'b0;
      if (busy_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_det) begin
        state    <= ST_DEV;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        commit_o <= (state == ST_WAIT_STOP);
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (shifting) begin
        if (scl_rise && !byte_full) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && byte_full) begin
          bitcnt <= '0;
          unique case (state)
            ST_DEV: begin
              if (dev_match(shreg, hw_addr_i)) begin
                sda_oe_o  <= 1'b1;
                dev_hit_o <= 1'b1;
                state     <= ST_DEV_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_ADR: begin
              req_o.addr <= shreg;
              sda_oe_o   <= 1'b1;
              state      <= ST_ADR_ACK;
            end
            default: begin
              req_o.data <= shreg;
              sda_oe_o   <= 1'b1;
              state      <= ST_DAT_ACK;
            end
          endcase
        end
      end else if (scl_fall) begin
        unique case (state)
          ST_DEV_ACK: begin sda_oe_o <= 1'b0; state <= ST_ADR; end
          ST_ADR_ACK: begin sda_oe_o <= 1'b0; state <= ST_DAT; end
          ST_DAT_ACK: begin sda_oe_o <= 1'b0; state <= ST_WAIT_STOP; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qpot_regfile.sv
module qpot_regfile
  import qpot_pkg::*;
#(
  parameter int NPOT        = 4,
  parameter int NDR         = 4,
  parameter int BUSY_CYCLES = 300
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_i,
  input  wr_req_t                      req_i,
  input  logic                         wp_i,
  output logic [NPOT*BYTE_W-1:0]       wiper_o,
  output logic [NPOT*NDR*BYTE_W-1:0]   dreg_o,
  output logic [BYTE_W-1:0]            status_o,
  output logic                         busy_o,
  output logic                         nv_start_o,
  output logic                         dreg_we_o
);
  localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1;
  localparam int DW = (NDR > 1) ? $clog2(NDR) : 1;
  localparam int SW = DW + 1;
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [SW-1:0]     status_q;
  logic              hit_status, hit_pot, nv_en;
  logic [PW-1:0]     pot_sel, pend_pot;
  logic [DW-1:0]     dr_sel, pend_dr;
  logic [BYTE_W-1:0] pend_data;
  logic [CW-1:0]     cnt_q;

  always_comb begin
    hit_status = (req_i.addr == STATUS_ADDR);
    hit_pot    = pot_in_range(req_i.addr, NPOT);
    pot_sel    = req_i.addr[PW-1:0];
    nv_en      = status_q[0];
    dr_sel     = status_q[SW-1:1];
    nv_start_o = commit_i & hit_pot & nv_en & wp_i;
    busy_o     = (cnt_q != '0);
    dreg_we_o  = (cnt_q == CW'(1));
    status_o   = BYTE_W'(status_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else if (commit_i && hit_status) status_q <= req_i.data[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pend_pot  <= '0;
      pend_dr   <= '0;
      pend_data <= '0;
    end else if (nv_start_o) begin
      cnt_q     <= CW'(BUSY_CYCLES);
      pend_pot  <= pot_sel;
      pend_dr   <= dr_sel;
      pend_data <= req_i.data;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic [BYTE_W-1:0] wiper_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wiper_q <= '0;
      else if (commit_i && hit_pot && pot_sel == PW'(p)) wiper_q <= req_i.data;
    end
    assign wiper_o[p*BYTE_W +: BYTE_W] = wiper_q;

    for (genvar d = 0; d < NDR; d++) begin : g_dr
      logic [BYTE_W-1:0] dr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dr_q <= '0;
        else if (dreg_we_o && pend_pot == PW'(p) && pend_dr == DW'(d)) dr_q <= pend_data;
      end
      assign dreg_o[(p*NDR+d)*BYTE_W +: BYTE_W] = dr_q;
    end
  end
endmodule

// File: rtl/qpot_ctrl.sv
module qpot_ctrl
  import qpot_pkg::*;
#(
  parameter int NPOT        = 4,
  parameter int NDR         = 4,
  parameter int BUSY_CYCLES = 300
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic [2:0]                 hw_addr_i,
  input  logic                       wp_i,
  output logic [NPOT*BYTE_W-1:0]     wiper_o,
  output logic [NPOT*NDR*BYTE_W-1:0] dreg_o,
  output logic [BYTE_W-1:0]          status_o,
  output logic                       busy_o
);
  logic    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic    dev_hit, commit, nv_start, dreg_we;
  wr_req_t req;

  qpot_bus_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  qpot_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .busy_i(busy_o), .hw_addr_i(hw_addr_i), .sda_oe_o(sda_oe_o),
    .dev_hit_o(dev_hit), .commit_o(commit), .req_o(req)
  );

  qpot_regfile #(.NPOT(NPOT), .NDR(NDR), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .req_i(req), .wp_i(wp_i),
    .wiper_o(wiper_o), .dreg_o(dreg_o), .status_o(status_o),
    .busy_o(busy_o), .nv_start_o(nv_start), .dreg_we_o(dreg_we)
  );
endmodule

// File: rtl/qpot_ctrl_chk.sv
module qpot_ctrl_chk #(
  parameter int NPOT        = 4,
  parameter int NDR         = 4,
  parameter int BUSY_CYCLES = 300
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic                  scl_s,
  input logic                  busy,
  input logic                  commit,
  input logic                  nv_start,
  input logic                  dreg_we,
  input logic                  dev_hit,
  input logic [NPOT*8-1:0]     wiper,
  input logic [NPOT*NDR*8-1:0] dreg
);
  localparam int LW = $clog2(BUSY_CYCLES + 2);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (busy) len_q <= len_q + LW'(1);
    else len_q <= '0;
  end

  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  assert_no_hit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_hit |-> !busy);
  assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_commit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
  assert_busy_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |=> busy);
  assert_wiper_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(commit));
  assert_dreg_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dreg) |-> $past(dreg_we));
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == LW'(BUSY_CYCLES)));
endmodule

bind qpot_ctrl qpot_ctrl_chk #(.NPOT(NPOT), .NDR(NDR), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .busy(busy_o),
  .commit(commit), .nv_start(nv_start), .dreg_we(dreg_we), .dev_hit(dev_hit),
  .wiper(wiper_o), .dreg(dreg_o)
);

// File: tb/sim_qpot_ctrl.sv
`timescale 1ns/1ps
module sim_qpot_ctrl;
  localparam int NPOT = 4, NDR = 4, BUSY = 300, H = 8;
  localparam logic [2:0] HW = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b1;
  logic [2:0] hw = HW;
  logic sda_oe, busy;
  logic [NPOT*8-1:0] wiper;
  logic [NPOT*NDR*8-1:0] dreg;
  logic [7:0] status;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  qpot_ctrl #(.NPOT(NPOT), .NDR(NDR), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .hw_addr_i(hw), .wp_i(wp), .wiper_o(wiper), .dreg_o(dreg),
    .status_o(status), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0, bad_rel = 0;
  logic [7:0] ew [NPOT];
  logic [7:0] ed [NPOT*NDR];
  logic [7:0] est;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [NPOT*8-1:0] pw;
    logic [NPOT*NDR*8-1:0] pd;
    for (int p = 0; p < NPOT; p++) pw[p*8 +: 8] = ew[p];
    for (int i = 0; i < NPOT*NDR; i++) pd[i*8 +: 8] = ed[i];
    chk({tag, " wipers"}, 128'(wiper), 128'(pw));
    chk({tag, " dregs"}, 128'(dreg), 128'(pd));
    chk({tag, " status"}, 128'(status), 128'(est));
  endtask

  task automatic bus_start;
    sda_m = 1'b1; clocks(H);
    scl_m = 1'b1; clocks(H);
    sda_m = 1'b0; clocks(H);
    scl_m = 1'b0; clocks(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; clocks(H);
    scl_m = 1'b1; clocks(H);
    sda_m = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; clocks(H);
      scl_m = 1'b1; clocks(H/2);
      if (sda_oe) bad_rel++;
      clocks(H/2);
      scl_m = 1'b0; clocks(2);
    end
    sda_m = 1'b1; clocks(H);
    scl_m = 1'b1; clocks(H/2);
    acked = sda_oe;
    clocks(H/2);
    scl_m = 1'b0; clocks(2);
  endtask

  task automatic xfer(input logic [7:0] b0, b1, b2, output logic [2:0] acks);
    logic a;
    bus_start;
    send_byte(b0, a); acks[2] = a;
    send_byte(b1, a); acks[1] = a;
    send_byte(b2, a); acks[0] = a;
    bus_stop;
  endtask

  task automatic measure_busy(output int len);
    len = 0;
    for (int w = 0; w < 20 && !busy; w++) @(negedge clk);
    while (busy) begin len++; @(negedge clk); end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10: watchdog expired actual=running expected=done");
    finish_run;
  end

  localparam logic [7:0] DEV = {4'b0101, HW, 1'b0};

  initial begin
    logic [2:0] acks;
    logic a;
    int len;
    for (int p = 0; p < NPOT; p++) ew[p] = 8'h00;
    for (int i = 0; i < NPOT*NDR; i++) ed[i] = 8'h00;
    est = 8'h00;
    clocks(5);
    // R1: reset state
    chk("R1 busy", 128'(busy), 128'(0));
    chk("R1 sda_oe", 128'(sda_oe), 128'(0));
    check_all("R1");
    rst_n = 1'b1; clocks(5);

    // R2: every device-select value, acknowledge computed from the rule
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic expa;
      b = 8'(v);
      expa = (b[7:4] == 4'b0101) && (b[3:1] == HW) && (b[0] == 1'b0);
      bus_start; send_byte(b, a); bus_stop; clocks(H);
      chk($sformatf("R2 select %02h ack", b), 128'(a), 128'(expa));
    end
    check_all("R2 after sweep");
    // R2: each strap value accepts only its own pattern
    for (int h = 0; h < 8; h++) begin
      hw = 3'(h);
      bus_start; send_byte({4'b0101, 3'(h), 1'b0}, a); bus_stop; clocks(H);
      chk("R2 strap match", 128'(a), 128'(1));
      bus_start; send_byte({4'b0101, 3'(h) ^ 3'b001, 1'b0}, a); bus_stop; clocks(H);
      chk("R2 strap mismatch", 128'(a), 128'(0));
    end
    hw = HW;
    // R2: refused device, later bytes are ignored
    xfer({4'b0101, HW ^ 3'b100, 1'b0}, 8'h01, 8'h77, acks); clocks(12);
    chk("R2 refused acks", 128'(acks), 128'(0));
    check_all("R2 refused write");

    // R4: steering register, upper bits masked
    for (int v = 0; v < 8; v++) begin
      logic [7:0] d;
      d = {5'(8'hA5 >> v), 3'(v)};
      bad_rel = 0;
      xfer(DEV, 8'h07, d, acks); clocks(12);
      est = {5'b0, 3'(v)};
      chk("R3 acks status", 128'(acks), 128'(3'b111));
      chk("R3 released on data bits", 128'(bad_rel), 128'(0));
      chk("R4 status value", 128'(status), 128'(est));
    end
    xfer(DEV, 8'h07, 8'h00, acks); clocks(12); est = 8'h00;

    // R5: volatile writes, enable clear
    for (int p = 0; p < NPOT; p++) begin
      logic [7:0] vals [3];
      vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'(8'h3A + 8'(p * 17));
      for (int k = 0; k < 3; k++) begin
        xfer(DEV, 8'(p), vals[k], acks); clocks(12);
        ew[p] = vals[k];
        chk("R5 acks", 128'(acks), 128'(3'b111));
        chk("R5 no busy", 128'(busy), 128'(0));
        check_all("R5 volatile");
      end
    end
    // R5: enable set but protected
    xfer(DEV, 8'h07, 8'h03, acks); clocks(12); est = 8'h03;
    wp = 1'b0;
    xfer(DEV, 8'h02, 8'h5C, acks); clocks(12); ew[2] = 8'h5C;
    chk("R5 protected no busy", 128'(busy), 128'(0));
    check_all("R5 protected");
    wp = 1'b1;

    // R9: unassigned addresses
    begin
      logic [7:0] bad [6];
      bad[0] = 8'h04; bad[1] = 8'h05; bad[2] = 8'h06;
      bad[3] = 8'h08; bad[4] = 8'h80; bad[5] = 8'hFF;
      for (int k = 0; k < 6; k++) begin
        xfer(DEV, bad[k], 8'h99, acks); clocks(12);
        chk("R9 acks", 128'(acks), 128'(3'b111));
        chk("R9 no busy", 128'(busy), 128'(0));
        check_all("R9 unassigned");
      end
    end

    // R8: cut short by STOP before the data byte, then by repeated START
    bus_start; send_byte(DEV, a); send_byte(8'h01, a); bus_stop; clocks(12);
    check_all("R8 stop after address");
    bus_start; send_byte(DEV, a); send_byte(8'h01, a); send_byte(8'hC3, a);
    bus_start; bus_stop; clocks(12);
    chk("R8 no busy", 128'(busy), 128'(0));
    check_all("R8 repeated start");

    // R6: non-volatile writes to every pot and data index
    for (int d = 0; d < NDR; d++) begin
      xfer(DEV, 8'h07, 8'({d, 1'b1}), acks); clocks(12);
      est = 8'({d, 1'b1});
      for (int p = 0; p < NPOT; p++) begin
        logic [7:0] v;
        v = 8'(8'h11 * (p + 1) + 8'(d * 4) + 8'd1);
        xfer(DEV, 8'(p), v, acks);
        for (int w = 0; w < 20 && !busy; w++) @(negedge clk);
        ew[p] = v;
        chk("R6 wiper at STOP", 128'(wiper[p*8 +: 8]), 128'(v));
        chk("R6 data reg not yet", 128'(dreg[(p*NDR+d)*8 +: 8]), 128'(ed[p*NDR+d]));
        len = 1;
        @(negedge clk);
        while (busy) begin len++; @(negedge clk); end
        chk("R6 busy length", 128'(len), 128'(BUSY));
        ed[p*NDR+d] = v;
        clocks(2);
        check_all("R6 after window");
      end
    end

    // R7: transfer inside the busy window is ignored
    xfer(DEV, 8'h03, 8'h42, acks);
    ew[3] = 8'h42;
    for (int w = 0; w < 20 && !busy; w++) @(negedge clk);
    chk("R7 busy open", 128'(busy), 128'(1));
    bus_start; send_byte(DEV, a);
    chk("R7 no ack while busy", 128'(a), 128'(0));
    send_byte(8'h01, a); send_byte(8'hEE, a); bus_stop;
    measure_busy(len);
    ed[3*NDR+3] = 8'h42;
    clocks(12);
    check_all("R7 ignored transfer");

    // R10: responds again once the window closes
    xfer(DEV, 8'h07, 8'h00, acks); clocks(12); est = 8'h00;
    chk("R10 acks after busy", 128'(acks), 128'(3'b111));
    xfer(DEV, 8'h01, 8'hA7, acks); clocks(12); ew[1] = 8'hA7;
    chk("R10 no busy volatile", 128'(busy), 128'(0));
    check_all("R10 write after busy");

    finish_run;
  end
endmodule